// File: doc/BRIEF.md
# Supply Low-Voltage Detect Register

This block is the software-visible side of a supply-voltage monitor. An analog comparator outside the block drives an asynchronous detect line. The block synchronizes that line and shows it as a live status bit. Each time the status changes in either direction, the block latches a sticky change flag. When software has enabled it, the block drives a level interrupt request while the flag stays set.

Software reaches the block through a byte-wide register port with an address, a write strobe, write data and combinational read data. The control register sits at one address and a reserved test register sits at the neighbouring address. The test register always reads zero and ignores writes. A low-power-entry input lets the surrounding power controller mark the start of reduced-power operation. The change flag keeps its value across that event, so a supply dip that happens just before sleep is not lost.

Top module: `lvd_regblock`

## Requirements
- R1: The control register is at address 1. Bit 2 is the status, bit 1 is the interrupt enable and bit 0 is the change flag. Bits 7 to 3 always read as zero.
- R2: The status bit shows the detect input after a two-flop synchronizer: it reads 1 two clock edges after the input goes to 1 (below threshold) and 0 after it returns. Writing bit 2 has no effect.
- R3: The interrupt enable can be read and written through bit 1. The irq output is a registered copy of (enable AND flag). It rises or falls one clock after either term changes.
- R4: The change flag becomes 1 on the clock edge after the status bit changes, for a rising change and for a falling change.
- R5: Writing 1 to bit 0 of the control register clears the flag. Writing 0 to bit 0 leaves it unchanged.
- R6: A pulse on lp_enter does not clear the flag, and it does not change the enable.
- R7: After reset, the enable, the flag, the status and irq are all 0.
- R8: The test register at address 0 reads 0x00. Writes to it change nothing in the control register or in irq.
- R9: When a status change and a write-one-to-clear fall on the same clock edge, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address (0 test, 1 control) |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| lp_enter | input | 1 | Pulse marking entry to reduced-power mode |
| vdet_async | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is the collision in which a clear write and a new status change hit the same clock edge. The bench makes it happen by counting the synchronizer depth. It changes the detect input, waits two rising edges, and then drives a write-one-to-clear strobe so that the write is sampled on the third edge, which is the edge where the flag sets. The same count lets the bench read the register between the second and third edges. There it confirms that the status has already changed while the flag has not yet set.

// File: rtl/lvd_pkg.sv
package lvd_pkg;

    localparam int DATA_W   = 8;
    localparam int STAT_BIT = 2;
    localparam int EN_BIT   = 1;
    localparam int FLAG_BIT = 0;

    typedef struct packed {
        logic status;
        logic en;
        logic flag;
    } ctrl_view_t;

    typedef struct packed {
        logic en;
        logic clr;
    } ctrl_wr_t;

    function automatic ctrl_wr_t decode_wr(input logic [DATA_W-1:0] d);
        ctrl_wr_t w;
        w.en  = d[EN_BIT];
        w.clr = d[FLAG_BIT];
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_view(input ctrl_view_t v);
        logic [DATA_W-1:0] b;
        b = '0;
        b[STAT_BIT] = v.status;
        b[EN_BIT]   = v.en;
        b[FLAG_BIT] = v.flag;
        return b;
    endfunction

endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lvd_flag_unit.sv
module lvd_flag_unit
    import lvd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     status,
    input  logic     wr_ctrl,
    input  ctrl_wr_t wr_fields,
    input  logic     lp_enter,
    output logic     en,
    output logic     flag,
    output logic     irq
);
    logic prev_status;
    logic change;
    logic clr_req;

    assign change  = status ^ prev_status;
    assign clr_req = wr_ctrl && wr_fields.clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_status <= 1'b0;
            en          <= 1'b0;
            flag        <= 1'b0;
            irq         <= 1'b0;
        end else begin
            prev_status <= status;
            if (wr_ctrl) en <= wr_fields.en;
            if (change)       flag <= 1'b1;
            else if (clr_req) flag <= 1'b0;
            irq <= en && flag;
        end
    end

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        change |=> flag);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (change && clr_req) |=> flag);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);

    // R6
    lp_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (lp_enter && flag && !clr_req) |=> flag);

    // R3
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (en && flag) |=> irq);

    // R3
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !(en && flag) |=> !irq);
endmodule

// File: rtl/lvd_regblock.sv
module lvd_regblock
    import lvd_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int CTRL_ADDR   = 1,
    parameter int TEST_ADDR   = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              lp_enter,
    input  logic              vdet_async,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] TEST_A = ADDR_W'(TEST_ADDR);

    logic       status;
    logic       wr_ctrl;
    ctrl_wr_t   wr_fields;
    ctrl_view_t view;

    lvd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (vdet_async),
        .q       (status)
    );

    assign wr_ctrl   = wr_en && (addr == CTRL_A);
    assign wr_fields = decode_wr(wr_data);

    lvd_flag_unit u_flag (
        .clk       (clk),
        .rst       (rst),
        .status    (status),
        .wr_ctrl   (wr_ctrl),
        .wr_fields (wr_fields),
        .lp_enter  (lp_enter),
        .en        (view.en),
        .flag      (view.flag),
        .irq       (irq)
    );

    assign view.status = status;

    // The test register holds no state: reads give zero.
    always_comb begin
        rd_data = '0;
        if (addr == CTRL_A) rd_data = pack_view(view);
    end

    // R8
    test_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == TEST_A) |-> (rd_data == 8'h00));

    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:3] == 5'b0);
endmodule

// File: tb/lvd_regblock_bench.sv
module lvd_regblock_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] addr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       lp_enter;
    logic       vdet_async;
    logic       irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    lvd_regblock u_lvd_regblock (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .lp_enter(lp_enter), .vdet_async(vdet_async), .irq(irq)
    );

    typedef struct packed {
        logic       vdet;
        logic       lp;
        logic       wr;
        logic [1:0] waddr;
        logic [7:0] wdata;
        logic [1:0] raddr;
        logic [7:0] exp_rd;
        logic       exp_irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,2'd1,8'h00,2'd1,8'h00,1'b0,4'd1}, // R1 idle
        '{1'b1,1'b0,1'b0,2'd1,8'h00,2'd1,8'h05,1'b0,4'd4}, // R4 R2 rise, enable off
        '{1'b1,1'b0,1'b1,2'd1,8'h02,2'd1,8'h07,1'b1,4'd3}, // R3 enable on
        '{1'b1,1'b0,1'b1,2'd1,8'h06,2'd1,8'h07,1'b1,4'd5}, // R5 R2 bit0=0 keeps flag
        '{1'b1,1'b0,1'b1,2'd1,8'h03,2'd1,8'h06,1'b0,4'd5}, // R5 clear
        '{1'b0,1'b0,1'b0,2'd1,8'h00,2'd1,8'h03,1'b1,4'd4}, // R4 falling change
        '{1'b0,1'b0,1'b1,2'd0,8'hFF,2'd1,8'h03,1'b1,4'd8}, // R8 test write ignored
        '{1'b0,1'b0,1'b0,2'd0,8'h00,2'd0,8'h00,1'b1,4'd8}, // R8 test reads zero
        '{1'b0,1'b1,1'b0,2'd1,8'h00,2'd1,8'h03,1'b1,4'd6}, // R6 low-power keeps flag
        '{1'b0,1'b0,1'b1,2'd1,8'h00,2'd1,8'h01,1'b0,4'd3}, // R3 enable off
        '{1'b0,1'b0,1'b1,2'd1,8'hF9,2'd1,8'h00,1'b0,4'd1}  // R1 upper bits ignored, clear
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; lp_enter = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr = 2'd1; vdet_async = 1'b0; idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        check("R7 rd", rd_data, 8'h00);
        check("R7 irq", {7'b0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            vdet_async = VECS[i].vdet; lp_enter = VECS[i].lp;
            wr_en = VECS[i].wr; addr = VECS[i].waddr; wr_data = VECS[i].wdata;
            @(negedge clk);
            idle(); addr = VECS[i].raddr;
            repeat (4) @(negedge clk);
            check($sformatf("R%0d vec%0d rd", VECS[i].req, i), rd_data, VECS[i].exp_rd);
            check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {7'b0, irq}, {7'b0, VECS[i].exp_irq});
        end

        // R2 and R4 latency: status visible after two edges, flag one edge later
        addr = 2'd1;
        vdet_async = 1'b1;          // driven at a negedge
        @(negedge clk);             // edge A passed
        check("R2 not yet", rd_data, 8'h00);
        @(negedge clk);             // edge B passed
        check("R2 status", rd_data, 8'h04);
        @(negedge clk);             // edge C passed
        check("R4 flag", rd_data, 8'h05);

        // R9 collision: clear write sampled on the edge that sets the flag
        wr_en = 1'b1; wr_data = 8'h03;   // clears flag, enables
        @(negedge clk);
        idle();
        check("R5 cleared", rd_data, 8'h06);
        vdet_async = 1'b0;
        @(negedge clk);             // A
        @(negedge clk);             // B
        wr_en = 1'b1; wr_data = 8'h03;   // sampled at C
        @(negedge clk);
        idle();
        check("R9 set wins", rd_data, 8'h03);
        @(negedge clk);
        check("R3 irq on", {7'b0, irq}, 8'h01);

        // R3 irq falls one edge after the flag clears
        wr_en = 1'b1; wr_data = 8'h03;
        @(negedge clk);
        idle();
        check("R3 irq lag", {7'b0, irq}, 8'h01);
        @(negedge clk);
        check("R3 irq off", {7'b0, irq}, 8'h00);

        // R7 reset mid-run clears enable and flag
        vdet_async = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        vdet_async = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R7 rerst rd", rd_data, 8'h00);
        check("R7 rerst irq", {7'b0, irq}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule